// File: doc/BRIEF.md
# Two-Resolution Interval SAD Bounder

This block brackets the sum of absolute differences between a reference block and a candidate block of 8x8 pixels. It works without computing the exact sum. Each pixel pair is reduced to its most significant bits at two coarse resolutions. At each resolution the distance between the coarse values gives a guaranteed lowest and highest possible true difference for that pixel, and these limits are summed over the block. The result is four sums: a lower and an upper bound at a 2-bit resolution (four intensity classes) and at a 4-bit resolution (sixteen classes). The exact 8-bit SAD always lies inside each interval.

A motion-search controller pulses `start`, then streams the 64 pixel pairs one per accepted cycle with `in_valid`. Pauses between pairs are allowed. Both resolutions are computed from that single stream, so the same pixels never need a second fetch. When the last pair has been accepted, `done` pulses for one cycle. The four sums then stay fixed until the next `start`, so downstream logic can compare them against a running best and discard the candidate early.

Top module: `mime_interval_bounder`

## Requirements
- R1: A `start` pulse returns all four bound outputs to 0 in the cycle after it and begins a new block, dropping any partly accumulated block.
- R2: The coarse value at the low resolution is pixel bits [7:6]; at the high resolution it is bits [7:4]. The coarse difference k is the absolute difference of the two coarse values.
- R3: Each accepted pair adds (k+1)*d-1 to its upper-bound sum, with quantum d=64 at the low resolution and d=16 at the high one. A full block of 255-against-0 pairs gives 16320 on both upper outputs with no overflow.
- R4: Each accepted pair adds (k-1)*d+1 to its lower-bound sum when k is at least 1, and 0 when k is 0. For 255-against-0 pairs that is 8256 at the low resolution and 14400 at the high one.
- R5: After a block, each lower bound is at or below the exact 8-bit SAD of the block, and each upper bound is at or above it.
- R6: The intervals are nested at all times: low-res lower ≤ high-res lower ≤ high-res upper ≤ low-res upper.
- R7: `done` is high for exactly one cycle, the cycle after the 64th accepted pair, and never earlier. Cycles with `in_valid` low are not counted.
- R8: After `done`, and before any `start` following reset, `in_valid` has no effect: the outputs hold their values and `done` stays low.
- R9: When `start` and `in_valid` are high in the same cycle, the start wins and that pixel pair is discarded.
- R10: While and after reset, all four outputs are 0 and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the sums and opens a new block |
| in_valid | input | 1 | The pixel pair on the data inputs is offered this cycle |
| ref_pix | input | 8 | Reference-block pixel intensity |
| cand_pix | input | 8 | Candidate-block pixel intensity |
| done | output | 1 | One-cycle pulse after the last pair of a block |
| sad_lo_ub | output | 14 | Upper bound, 2-bit resolution |
| sad_lo_lb | output | 14 | Lower bound, 2-bit resolution |
| sad_hi_ub | output | 14 | Upper bound, 4-bit resolution |
| sad_hi_lb | output | 14 | Lower bound, 4-bit resolution |

## Verification
Two events can land on the same clock edge: a new block opening and a pixel pair being offered. Both also collide with the pulse that closes a block. The bench raises `start` and `in_valid` together with a 255-against-0 pair on the data inputs, then streams a block of equal pixels. If the colliding pair were counted, the sums would rise above the equal-pixel values and `done` would arrive one pair early, so both the sums and the timing of `done` are compared with the model. A restart in the middle of a block of large differences is checked the same way. The outputs must read zero one cycle after the restart, and the following block must carry none of the abandoned sums.

// File: rtl/mime_bound_pkg.sv
package mime_bound_pkg;

    // Number of coarse resolutions evaluated in parallel
    localparam int NUM_RES = 2;

    // Block sequencer state
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Sequencer outputs toward the datapath
    typedef struct packed {
        logic clr;
        logic accept;
    } seq_ctl_t;

    // Width needed to hold the sum of n values each at most (2^pw - 1)
    function automatic int sum_width(input int n, input int pw);
        longint unsigned top;
        int w;
        top = longint'(n) * ((longint'(1) << pw) - 1);
        w = 1;
        while ((longint'(1) << w) <= top) w++;
        return w;
    endfunction

endpackage

// File: rtl/mime_pixel_bound.sv
module mime_pixel_bound #(
    parameter int PIX_W = 8,
    parameter int RES_B = 2
) (
    input  logic [PIX_W-1:0] ref_pix,
    input  logic [PIX_W-1:0] cand_pix,
    output logic [PIX_W-1:0] lo_bound,
    output logic [PIX_W-1:0] hi_bound
);
    // Bits dropped by truncation; quantum is 2^SH
    localparam int SH = PIX_W - RES_B;

    logic [RES_B-1:0] coarse_r, coarse_c, kdist, kdist_m1;
    logic [PIX_W-1:0] km1_wide;

    always_comb begin
        coarse_r = ref_pix[PIX_W-1 -: RES_B];
        coarse_c = cand_pix[PIX_W-1 -: RES_B];
        kdist    = (coarse_r >= coarse_c) ? (coarse_r - coarse_c) : (coarse_c - coarse_r);
        kdist_m1 = kdist - RES_B'(1);
        km1_wide = {{SH{1'b0}}, kdist_m1};

        // Largest true distance: k*d + (d-1)
        hi_bound = {kdist, {SH{1'b1}}};

        // Smallest true distance: (k-1)*d + 1, or 0 when classes match
        if (kdist == '0)
            lo_bound = '0;
        else
            lo_bound = (km1_wide << SH) | PIX_W'(1);
    end

endmodule

// File: rtl/mime_bound_acc.sv
module mime_bound_acc #(
    parameter int IN_W  = 8,
    parameter int ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [IN_W-1:0]  lo_in,
    input  logic [IN_W-1:0]  hi_in,
    output logic [ACC_W-1:0] lo_sum,
    output logic [ACC_W-1:0] hi_sum
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_sum <= '0;
            hi_sum <= '0;
        end else if (en) begin
            lo_sum <= lo_sum + ACC_W'(lo_in);
            hi_sum <= hi_sum + ACC_W'(hi_in);
        end
    end

endmodule

// File: rtl/mime_block_seq.sv
module mime_block_seq
    import mime_bound_pkg::*;
#(
    parameter int BLK_PIX = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     in_valid,
    output seq_ctl_t ctl,
    output logic     done
);
    localparam int CNT_W = (BLK_PIX > 1) ? $clog2(BLK_PIX) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_PIX - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] beat;

    // A start always takes precedence over a pair offered in the same cycle
    always_comb begin
        ctl.clr    = start;
        ctl.accept = (state == SEQ_RUN) && in_valid && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            beat  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state <= SEQ_RUN;
                beat  <= '0;
            end else if (ctl.accept) begin
                if (beat == LAST) begin
                    state <= SEQ_IDLE;
                    beat  <= '0;
                    done  <= 1'b1;
                end else begin
                    beat <= beat + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/mime_interval_bounder.sv
module mime_interval_bounder
    import mime_bound_pkg::*;
#(
    parameter  int PIX_W   = 8,
    parameter  int BLK_PIX = 64,
    parameter  int LO_BITS = 2,
    parameter  int HI_BITS = 4,
    localparam int ACC_W   = sum_width(BLK_PIX, PIX_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] ref_pix,
    input  logic [PIX_W-1:0] cand_pix,
    output logic             done,
    output logic [ACC_W-1:0] sad_lo_ub,
    output logic [ACC_W-1:0] sad_lo_lb,
    output logic [ACC_W-1:0] sad_hi_ub,
    output logic [ACC_W-1:0] sad_hi_lb
);

    seq_ctl_t         ctl;
    logic [PIX_W-1:0] pix_lb [NUM_RES];
    logic [PIX_W-1:0] pix_ub [NUM_RES];
    logic [ACC_W-1:0] acc_lb [NUM_RES];
    logic [ACC_W-1:0] acc_ub [NUM_RES];

    mime_block_seq #(
        .BLK_PIX (BLK_PIX)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .ctl      (ctl),
        .done     (done)
    );

    // One bound cell and one accumulator pair per resolution, same pixel stream
    for (genvar gi = 0; gi < NUM_RES; gi++) begin : g_res
        localparam int RB = (gi == 0) ? LO_BITS : HI_BITS;

        mime_pixel_bound #(
            .PIX_W (PIX_W),
            .RES_B (RB)
        ) u_cell (
            .ref_pix  (ref_pix),
            .cand_pix (cand_pix),
            .lo_bound (pix_lb[gi]),
            .hi_bound (pix_ub[gi])
        );

        mime_bound_acc #(
            .IN_W  (PIX_W),
            .ACC_W (ACC_W)
        ) u_acc (
            .clk    (clk),
            .rst    (rst),
            .clr    (ctl.clr),
            .en     (ctl.accept),
            .lo_in  (pix_lb[gi]),
            .hi_in  (pix_ub[gi]),
            .lo_sum (acc_lb[gi]),
            .hi_sum (acc_ub[gi])
        );
    end

    assign sad_lo_lb = acc_lb[0];
    assign sad_lo_ub = acc_ub[0];
    assign sad_hi_lb = acc_lb[1];
    assign sad_hi_ub = acc_ub[1];

endmodule

// File: rtl/mime_interval_bounder_chk.sv
module mime_interval_bounder_chk #(
    parameter int PIX_W   = 8,
    parameter int BLK_PIX = 64,
    parameter int ACC_W   = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic             done,
    input logic [ACC_W-1:0] sad_lo_ub,
    input logic [ACC_W-1:0] sad_lo_lb,
    input logic [ACC_W-1:0] sad_hi_ub,
    input logic [ACC_W-1:0] sad_hi_lb
);
    localparam longint MAX_SUM = longint'(BLK_PIX) * ((longint'(1) << PIX_W) - 1);

    // R1: a start leaves every sum at zero on the next cycle
    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (sad_lo_ub == '0 && sad_lo_lb == '0 && sad_hi_ub == '0 && sad_hi_lb == '0));

    // R3: upper sums never exceed a full block of maximum differences
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (longint'(sad_lo_ub) <= MAX_SUM) && (longint'(sad_hi_ub) <= MAX_SUM));

    // R6: coarse interval always encloses the fine one
    a_r6_nested: assert property (@(posedge clk) disable iff (rst)
        (sad_lo_lb <= sad_hi_lb) && (sad_hi_lb <= sad_hi_ub) && (sad_hi_ub <= sad_lo_ub));

    // R7: completion strobe lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: with no new start, results after completion hold despite in_valid
    a_r8_hold_after_done: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(sad_lo_ub) && $stable(sad_lo_lb) &&
                              $stable(sad_hi_ub) && $stable(sad_hi_lb)));

endmodule

bind mime_interval_bounder mime_interval_bounder_chk #(
    .PIX_W   (PIX_W),
    .BLK_PIX (BLK_PIX),
    .ACC_W   (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .done      (done),
    .sad_lo_ub (sad_lo_ub),
    .sad_lo_lb (sad_lo_lb),
    .sad_hi_ub (sad_hi_ub),
    .sad_hi_lb (sad_hi_lb)
);

// File: tb/mime_interval_bounder_bench.sv
`timescale 1ns/1ps
module mime_interval_bounder_bench;
    localparam int BLK   = 64;
    localparam int ACC_W = 14;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       ref_pix = '0;
    logic [7:0]       cand_pix = '0;
    logic             done;
    logic [ACC_W-1:0] sad_lo_ub, sad_lo_lb, sad_hi_ub, sad_hi_lb;

    always #10 clk = ~clk;

    mime_interval_bounder u_mime_interval_bounder (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .ref_pix   (ref_pix),
        .cand_pix  (cand_pix),
        .done      (done),
        .sad_lo_ub (sad_lo_ub),
        .sad_lo_lb (sad_lo_lb),
        .sad_hi_ub (sad_hi_ub),
        .sad_hi_lb (sad_hi_lb)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] rb [BLK];
    logic [7:0] cb [BLK];

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model from the requirements: d = 256 / 2^bits, k = |a/d - b/d|
    function automatic int px_hi(input int a, input int b, input int bits);
        int d, k;
        d = 256 / (1 << bits);
        k = (a / d > b / d) ? (a / d - b / d) : (b / d - a / d);
        return (k + 1) * d - 1;
    endfunction

    function automatic int px_lo(input int a, input int b, input int bits);
        int d, k;
        d = 256 / (1 << bits);
        k = (a / d > b / d) ? (a / d - b / d) : (b / d - a / d);
        return (k == 0) ? 0 : (k - 1) * d + 1;
    endfunction

    function automatic int blk_hi(input int bits);
        int s = 0;
        for (int i = 0; i < BLK; i++) s += px_hi(int'(rb[i]), int'(cb[i]), bits);
        return s;
    endfunction

    function automatic int blk_lo(input int bits);
        int s = 0;
        for (int i = 0; i < BLK; i++) s += px_lo(int'(rb[i]), int'(cb[i]), bits);
        return s;
    endfunction

    function automatic int blk_exact();
        int s = 0;
        for (int i = 0; i < BLK; i++)
            s += (rb[i] > cb[i]) ? int'(rb[i] - cb[i]) : int'(cb[i] - rb[i]);
        return s;
    endfunction

    task automatic check_model(input string tag);
        chk({tag, " R3 lo_ub"}, int'(sad_lo_ub), blk_hi(2));
        chk({tag, " R4 lo_lb"}, int'(sad_lo_lb), blk_lo(2));
        chk({tag, " R3 hi_ub"}, int'(sad_hi_ub), blk_hi(4));
        chk({tag, " R4 hi_lb"}, int'(sad_hi_lb), blk_lo(4));
    endtask

    // Opens a block and streams rb/cb; optional collision and bubbles
    task automatic run_block(input bit collide, input bit bubbles);
        int early;
        early = 0;
        @(negedge clk);
        start = 1'b1; in_valid = collide; ref_pix = 8'd255; cand_pix = 8'd0;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        for (int i = 0; i < BLK; i++) begin
            if (bubbles && (i % 7 == 3)) begin
                in_valid = 1'b0;
                @(negedge clk);
                if (done) early++;
            end
            in_valid = 1'b1; ref_pix = rb[i]; cand_pix = cb[i];
            @(negedge clk);
            if (i < BLK - 1 && done) early++;
        end
        in_valid = 1'b0;
        chk("R7 no early done", early, 0);
        chk("R7 done after last pair", int'(done), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 done in reset", int'(done), 0);
        chk("R10 sums in reset", int'(sad_lo_ub | sad_lo_lb | sad_hi_ub | sad_hi_lb), 0);
        rst = 1'b0;
        // R8: in_valid before any start is ignored
        in_valid = 1'b1; ref_pix = 8'd255; cand_pix = 8'd0;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk("R8 idle after reset", int'(sad_lo_ub), 0);
        chk("R8 no done when idle", int'(done), 0);
    endtask

    task automatic t_extreme();
        for (int i = 0; i < BLK; i++) begin rb[i] = 8'd255; cb[i] = 8'd0; end
        run_block(1'b0, 1'b0);
        chk("R3 extreme lo_ub", int'(sad_lo_ub), 16320);
        chk("R4 extreme lo_lb", int'(sad_lo_lb), 8256);
        chk("R3 extreme hi_ub", int'(sad_hi_ub), 16320);
        chk("R4 extreme hi_lb", int'(sad_hi_lb), 14400);
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_truncation();
        // 0x3F vs 0x40: low-res classes 0/1, high-res classes 3/4
        for (int i = 0; i < BLK; i++) begin rb[i] = 8'h3F; cb[i] = 8'h40; end
        run_block(1'b0, 1'b0);
        chk("R2 trunc lo_ub", int'(sad_lo_ub), 127 * 64);
        chk("R2 trunc lo_lb", int'(sad_lo_lb), 64);
        chk("R2 trunc hi_ub", int'(sad_hi_ub), 31 * 64);
        chk("R2 trunc hi_lb", int'(sad_hi_lb), 64);
    endtask

    task automatic t_random(input bit bubbles);
        int ex;
        for (int i = 0; i < BLK; i++) begin
            rb[i] = 8'($urandom_range(0, 255));
            cb[i] = 8'($urandom_range(0, 255));
        end
        run_block(1'b0, bubbles);
        check_model("random");
        ex = blk_exact();
        chk("R5 lo_lb <= exact", int'(int'(sad_lo_lb) <= ex), 1);
        chk("R5 exact <= lo_ub", int'(ex <= int'(sad_lo_ub)), 1);
        chk("R5 hi_lb <= exact", int'(int'(sad_hi_lb) <= ex), 1);
        chk("R5 exact <= hi_ub", int'(ex <= int'(sad_hi_ub)), 1);
        chk("R6 nested", int'(sad_lo_lb <= sad_hi_lb && sad_hi_ub <= sad_lo_ub), 1);
    endtask

    task automatic t_idle_after_done();
        int ub0, lb0;
        ub0 = int'(sad_lo_ub); lb0 = int'(sad_hi_lb);
        @(negedge clk);
        in_valid = 1'b1; ref_pix = 8'd0; cand_pix = 8'd255;
        repeat (5) @(negedge clk);
        chk("R8 done stays low", int'(done), 0);
        in_valid = 1'b0;
        chk("R8 lo_ub held", int'(sad_lo_ub), ub0);
        chk("R8 hi_lb held", int'(sad_hi_lb), lb0);
    endtask

    task automatic t_collision();
        // Equal pixels: any counted 255/0 pair would raise the sums
        for (int i = 0; i < BLK; i++) begin rb[i] = 8'd0; cb[i] = 8'd0; end
        run_block(1'b1, 1'b0);
        chk("R9 collide lo_ub", int'(sad_lo_ub), 63 * 64);
        chk("R9 collide hi_ub", int'(sad_hi_ub), 15 * 64);
        chk("R9 collide lo_lb", int'(sad_lo_lb), 0);
    endtask

    task automatic t_restart();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b1; ref_pix = 8'd255; cand_pix = 8'd0;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 cleared on restart", int'(sad_lo_ub | sad_lo_lb | sad_hi_ub | sad_hi_lb), 0);
        for (int i = 0; i < BLK; i++) begin
            rb[i] = 8'($urandom_range(0, 255));
            cb[i] = rb[i];
        end
        run_block(1'b0, 1'b1);
        check_model("R1 restart");
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_extreme();
        t_idle_after_done();
        t_truncation();
        for (int r = 0; r < 4; r++) t_random(r[0]);
        t_collision();
        t_restart();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule